// File: doc/BRIEF.md
# Per-Target Interrupt Priority Selector

This block serves one interrupt target. Each cycle it looks at the pending vector from the source gateways, the target's enable mask, the priority of every source and the target's threshold. It selects the best eligible source and registers two results: the ID that a claim would return, and a request line to the target.

The search is a balanced binary comparison tree over all sources. At each node the lower-ID branch wins a tie. The claim ID and the request line use different rules. The ID is the best candidate whatever the threshold is. The request line rises only when that candidate's priority is strictly above the threshold.

The block is meant to be used once per target. The register interface and the gateways are outside it. A claim clears the pending bit upstream, so the next-best source appears at the outputs one cycle later.

Top module: `prio_pick`

## Requirements
- R1: A source is a candidate only when its pending bit and its enable bit are both 1. Source 0 is never a candidate, whatever its inputs are.
- R2: `id_o` is the ID of the candidate with the highest priority. The priority of source i is `prio_i[i*PW +: PW]`, where PW = clog2(MAXP+1).
- R3: When several candidates share the highest priority, `id_o` is the lowest of their IDs.
- R4: `id_o` does not depend on `thr_i`. A winner at or below the threshold is still reported, with `req_o` low.
- R5: `req_o` is 1 exactly when a candidate exists and the winner's priority is strictly greater than `thr_i`. Equal priority gives 0.
- R6: A winner with priority 0 never raises `req_o`. Setting `thr_i` to MAXP holds `req_o` low for any inputs.
- R7: With no candidate, `id_o` is 0 and `req_o` is 0.
- R8: Both outputs are registered. They reflect the inputs sampled at the previous rising clock edge.
- R9: When the winner's pending bit drops, the next-best candidate is presented on the following cycle. A higher-priority source that becomes pending takes over in the same way.
- R10: While `rst_n` is low, `id_o` is 0 and `req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | NSRC | Pending bit per source, bit i is source i |
| en_i | input | NSRC | Target enable bit per source |
| prio_i | input | NSRC*PW | Packed priorities, source i in bits i*PW +: PW |
| thr_i | input | PW | Target threshold |
| id_o | output | IW | Winning source ID, 0 when none; IW = clog2(NSRC) |
| req_o | output | 1 | Interrupt request to the target |

## Verification
A wrong node in the comparison tree shows up at `id_o` one cycle after the inputs that expose it. Such inputs are typically equal priorities on sibling subtrees, or a winner that moves between halves of the vector. A fault in the threshold compare shows up at `req_o` on that same cycle, most sharply when the priority equals the threshold. Since every output bit is checked on every cycle against a behavioural linear scan, a fault appears within one clock of the first stimulus that reaches it. The directed cases place ties and boundary values at positions that exercise every tree level.

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NSRC = 32,
  parameter int MAXP = 7,
  localparam int PW = $clog2(MAXP + 1),
  localparam int IW = $clog2(NSRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    pend_i,
  input  logic [NSRC-1:0]    en_i,
  input  logic [NSRC*PW-1:0] prio_i,
  input  logic [PW-1:0]      thr_i,
  output logic [IW-1:0]      id_o,
  output logic               req_o
);

  localparam int NP = 1 << IW;

  logic [NSRC-1:0] cand;
  assign cand = pend_i & en_i & {{(NSRC-1){1'b1}}, 1'b0};

  logic          nv [1:2*NP-1];
  logic [PW-1:0] np [1:2*NP-1];
  logic [IW-1:0] ni [1:2*NP-1];

  for (genvar g = 0; g < NP; g++) begin : g_leaf
    if (g > 0 && g < NSRC) begin : g_src
      assign nv[NP+g] = cand[g];
      assign np[NP+g] = prio_i[g*PW +: PW];
    end else begin : g_pad
      assign nv[NP+g] = 1'b0;
      assign np[NP+g] = '0;
    end
    assign ni[NP+g] = IW'(g);
  end

  for (genvar k = 1; k < NP; k++) begin : g_node
    logic lw;
    assign lw    = nv[2*k] && (!nv[2*k+1] || np[2*k] >= np[2*k+1]);
    assign nv[k] = nv[2*k] || nv[2*k+1];
    assign np[k] = lw ? np[2*k] : np[2*k+1];
    assign ni[k] = lw ? ni[2*k] : ni[2*k+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_o  <= '0;
      req_o <= 1'b0;
    end else begin
      id_o  <= nv[1] ? ni[1] : '0;
      req_o <= nv[1] && (np[1] > thr_i);
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |=> (id_o == '0 && !req_o)); // R7
  AST_REQ_HAS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (id_o != '0)); // R5
  AST_MAXTHR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_i >= PW'(MAXP)) |=> !req_o); // R6
  AST_CAND_GIVES_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (cand != '0) |=> (id_o != '0)); // R1

endmodule

// File: tb/test_prio_pick.sv
`timescale 1ns/1ps
module test_prio_pick;
  localparam int NSRC = 32;
  localparam int MAXP = 7;
  localparam int PW = $clog2(MAXP + 1);
  localparam int IW = $clog2(NSRC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] pend = '0, en = '0;
  logic [NSRC*PW-1:0] prio = '0;
  logic [PW-1:0] thr = '0;
  logic [IW-1:0] id;
  logic req;

  int checks = 0, fails = 0;
  int exp_id;
  bit exp_req;

  always #2.5 clk = ~clk;

  prio_pick #(.NSRC(NSRC), .MAXP(MAXP)) i_prio_pick (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en),
    .prio_i(prio), .thr_i(thr), .id_o(id), .req_o(req));

  task automatic set_p(int s, int v);
    prio[s*PW +: PW] = PW'(v);
  endtask

  task automatic model();
    int best = -1;
    exp_id = 0;
    for (int i = 1; i < NSRC; i++)
      if (pend[i] && en[i] && int'(prio[i*PW +: PW]) > best) begin
        best = int'(prio[i*PW +: PW]);
        exp_id = i;
      end
    exp_req = (best >= 0) && (best > int'(thr));
  endtask

  task automatic compare(string tag);
    checks++;
    if (int'(id) != exp_id || req !== exp_req) begin
      fails++;
      $display("FAIL %s id=%0d exp=%0d req=%0b exp=%0b", tag, id, exp_id, req, exp_req);
    end
  endtask

  task automatic tick(string tag);
    model();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    pend = '1; en = '1; thr = '0;
    for (int i = 0; i < NSRC; i++) set_p(i, 5);
    exp_id = 0; exp_req = 0;
    for (int n = 0; n < 3; n++) begin @(negedge clk); compare("R10"); end
    pend = '0;
    rst_n = 1'b1;
    tick("R7");
    // R1: pending but disabled, enabled but not pending, source 0
    pend = 32'h0000_0011; en = 32'h0000_0100; tick("R1");
    pend = 32'h0000_0001; en = 32'h0000_0001; set_p(0, 7); tick("R1");
    // R2: highest priority
    pend = '0; en = '1; thr = 1;
    set_p(3, 2); set_p(9, 5); set_p(20, 4);
    pend[3] = 1; pend[9] = 1; pend[20] = 1; tick("R2");
    set_p(31, 6); pend[31] = 1; tick("R2");
    // R3: ties go to lower id, across tree halves
    set_p(5, 6); pend[5] = 1; tick("R3");
    pend = '0; set_p(17, 3); set_p(30, 3); pend[17] = 1; pend[30] = 1; tick("R3");
    set_p(16, 3); pend[16] = 1; tick("R3");
    // R4: id independent of threshold
    thr = 6; tick("R4");
    thr = 3; tick("R4");
    // R5: strict compare
    thr = 2; tick("R5");
    pend = '0; set_p(12, 4); pend[12] = 1; thr = 4; tick("R5");
    thr = 3; tick("R5");
    // R6: priority zero, max threshold
    pend = '0; set_p(7, 0); pend[7] = 1; thr = 0; tick("R6");
    set_p(7, 7); thr = PW'(MAXP); tick("R6");
    pend = '1; for (int i = 1; i < NSRC; i++) set_p(i, 7); tick("R6");
    // R9: claim sequence
    thr = 0; pend = '0;
    set_p(2, 3); set_p(14, 6); set_p(25, 5); set_p(8, 7);
    pend[2] = 1; pend[14] = 1; pend[25] = 1; tick("R9");
    pend[14] = 0; tick("R9");
    pend[8] = 1; tick("R9");
    pend[8] = 0; tick("R9");
    pend[25] = 0; tick("R9");
    pend[2] = 0; tick("R9");
    // R8: inputs changing every cycle
    for (int n = 0; n < 40; n++) begin
      pend = '0; pend[n % NSRC] = 1; pend[(n * 7) % NSRC] = 1;
      set_p(n % NSRC, n % 8); set_p((n * 7) % NSRC, (n + 3) % 8);
      thr = PW'(n % 5);
      tick("R8");
    end
    // R2: random patterns
    for (int n = 0; n < 3000; n++) begin
      pend = $urandom; en = $urandom;
      for (int i = 0; i < NSRC; i++) set_p(i, int'($urandom_range(MAXP, 0)));
      thr = PW'($urandom_range(MAXP, 0));
      tick("R2");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule